// File: doc/BRIEF.md
# Banked Asynchronous SRAM Sequencer

This block sits between a clocked host and an 8-bit-wide asynchronous static RAM module of 2M words. The module holds four 512K x 8 banks behind its own 1-of-4 decoder. The decoder uses address bits 20:19 to pick the bank, and bits 18:0 address a byte inside it. The host issues one read or write at a time through a valid/ready handshake. The sequencer turns each request into properly ordered edges on four signals: the address bus, an active-low module select, an active-low write strobe and an active-low output enable. It also drives the outgoing half of the shared data bus through a separate driver-enable.

Every phase of a memory cycle lasts a whole number of clock periods, and each count is a parameter. The defaults are worked out from the clock period and the memory's timing figures. A write opens with address and select in place. The write strobe then goes low for a set number of cycles, and it is always the first strobe to rise, so it ends the write. Address, select and data stay in place for a hold interval after that rise. A read first releases the data bus for one cycle, then lowers output enable for the access count. It samples the bus on the last access cycle and returns the byte with a one-cycle valid pulse.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After reset, and whenever no request is in progress, module select, write strobe and output enable are all high, the data driver is off, and `req_ready` is high.
- R2: In a write, module select goes low with the request's address on the bus exactly `SETUP_CYC` cycles before the write strobe falls, and output enable stays high for the whole write.
- R3: The write strobe stays low for exactly `PULSE_CYC` cycles and only while module select is low. It rises before module select does. Module select then stays low for exactly `HOLD_CYC` more cycles, with the address unchanged from the start of the cycle.
- R4: During a write the data driver is on from the cycle module select falls to the cycle it rises, and it carries the request's byte unchanged, including the cycle after the write strobe rises.
- R5: The data driver is never on while output enable is low, and the write strobe is never low while output enable is low.
- R6: In a read, module select is low for one turnaround cycle with output enable high and the bus released. Output enable is then low for exactly `RD_CYC` cycles, with the write strobe high throughout.
- R7: The byte on the bus during the last output-enable cycle is returned on `rsp_rdata`, with `rsp_valid` high for one cycle. That cycle is `RD_CYC + 1` cycles after the accepting clock edge.
- R8: `req_ready` is low from the clock edge that accepts a request until the memory cycle has finished, and a request held valid meanwhile is accepted only after that.
- R9: All 21 address bits reach the memory bus unchanged, so the same in-bank offset in each of the four banks (bits 20:19 = 0..3) holds a separate byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Byte address; bits 20:19 select the bank |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse: read byte available |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 21 | Memory address bus |
| mem_sel_n | output | 1 | Active-low module select |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_rd_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Outgoing data bus value |
| mem_dq_drive | output | 1 | 1 = sequencer drives the data bus |
| mem_dq_in | input | 8 | Incoming data bus value |

## Verification
Writing one offset in all four banks and reading it back separates a correct bank decode from one that drops or aliases the top address bits. Reads from the lowest and highest addresses, with all-zero and all-one bytes, expose bit-order and width faults. The memory model in the bench returns a decoy byte until the final access cycle, so any sample taken a cycle early shows up as a data mismatch and not as a timing artefact. Back-to-back requests, with the next one held valid while the sequencer is busy, show whether a request can slip in early and whether the turnaround cycle appears between a write and the read after it.

// File: rtl/sram_seq_pkg.sv
// Shared types and helpers for the banked SRAM sequencer.
// Assumes all timing values are positive integers.
package sram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_RTURN,
        ST_RACCESS
    } seq_state_t;

    // Whole clock periods covering a time in picoseconds (rounded up).
    function automatic int cycles_for(input int span_ps, input int clk_ps);
        return (span_ps + clk_ps - 1) / clk_ps;
    endfunction

    // Largest of four counts, used to size the phase counter.
    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/sram_seq_timer.sv
// Down-counter that times one sequencer phase.
// It loads a value when a phase is entered and counts down to zero.
// Assumes the loaded value is the phase length minus one.
module sram_seq_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // Load on phase entry, otherwise count down until zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
// Phase sequencer for the SRAM bus. It sets the order of the phases and
// registers the strobes from the next state, so every edge leaves a flop.
// Assumes all phase counts are at least one.
module sram_seq_fsm
    import sram_seq_pkg::*;
#(
    parameter int SETUP_CYC = 1,
    parameter int PULSE_CYC = 17,
    parameter int HOLD_CYC  = 1,
    parameter int RD_CYC    = 18,
    parameter int CNT_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_fire,
    input  logic             req_write,
    input  logic             expired,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             idle,
    output logic             capture,
    output logic             sel_n,
    output logic             wr_n,
    output logic             rd_n,
    output logic             drive
);
    localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] RD_LD    = CNT_W'(RD_CYC - 1);

    seq_state_t state_q, state_d;

    // Next-phase choice and timer reload on every phase change.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: if (req_fire) begin
                tmr_load = 1'b1;
                if (req_write) begin
                    state_d = ST_WSETUP;
                    tmr_val = SETUP_LD;
                end else begin
                    state_d = ST_RTURN;
                    tmr_val = '0;
                end
            end
            ST_WSETUP: if (expired) begin
                state_d  = ST_WPULSE;
                tmr_load = 1'b1;
                tmr_val  = PULSE_LD;
            end
            ST_WPULSE: if (expired) begin
                state_d  = ST_WHOLD;
                tmr_load = 1'b1;
                tmr_val  = HOLD_LD;
            end
            ST_WHOLD: if (expired) state_d = ST_IDLE;
            ST_RTURN: begin
                state_d  = ST_RACCESS;
                tmr_load = 1'b1;
                tmr_val  = RD_LD;
            end
            ST_RACCESS: if (expired) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Strobes registered from the next phase, all inactive in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_n <= 1'b1;
            wr_n  <= 1'b1;
            rd_n  <= 1'b1;
            drive <= 1'b0;
        end else begin
            sel_n <= (state_d == ST_IDLE);
            wr_n  <= (state_d != ST_WPULSE);
            rd_n  <= (state_d != ST_RACCESS);
            drive <= (state_d == ST_WSETUP) || (state_d == ST_WPULSE) ||
                     (state_d == ST_WHOLD);
        end
    end

    assign idle    = (state_q == ST_IDLE);
    assign capture = (state_q == ST_RACCESS) && expired;
endmodule

// File: rtl/sram_seq_rdcap.sv
// Read-return stage: samples the incoming bus when told to and presents
// the byte for one cycle with a valid pulse.
// Assumes the capture strobe is high only on the last access cycle.
module sram_seq_rdcap #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    // Sample the bus and raise the valid pulse for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= capture;
            if (capture) rsp_rdata <= dq_in;
        end
    end
endmodule

// File: rtl/sram_seq_ctrl.sv
// Top of the banked SRAM sequencer. It accepts one request at a time,
// latches its address and data, and has the phase sequencer run the
// memory cycle. The address is passed through whole so that the module's
// decoder can pick the bank from the top bits.
// Assumes the memory drives mem_dq_in only while it is read.
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int ADDR_W    = 21,
    parameter int DATA_W    = 8,
    parameter int CLK_PS    = 4000,
    parameter int T_RC_PS   = 70000,
    parameter int T_WP_PS   = 65000,
    parameter int SETUP_CYC = 1,
    parameter int PULSE_CYC = cycles_for(T_WP_PS, CLK_PS),
    parameter int HOLD_CYC  = 1,
    parameter int RD_CYC    = cycles_for(T_RC_PS, CLK_PS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_wr_n,
    output logic              mem_rd_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_drive,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int MAX_CYC = max_of4(SETUP_CYC, PULSE_CYC, HOLD_CYC, RD_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic             idle, req_fire, tmr_load, expired, capture;
    logic [CNT_W-1:0] tmr_val;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    assign req_ready = idle;
    assign req_fire  = req_valid && idle;

    // Latch the request so the bus holds steady for the whole cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (req_fire) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;

    sram_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (expired)
    );

    sram_seq_fsm #(
        .SETUP_CYC (SETUP_CYC),
        .PULSE_CYC (PULSE_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .RD_CYC    (RD_CYC),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_fire  (req_fire),
        .req_write (req_write),
        .expired   (expired),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .idle      (idle),
        .capture   (capture),
        .sel_n     (mem_sel_n),
        .wr_n      (mem_wr_n),
        .rd_n      (mem_rd_n),
        .drive     (mem_dq_drive)
    );

    sram_seq_rdcap #(.DATA_W(DATA_W)) u_rdcap (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .dq_in     (mem_dq_in),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );
endmodule

// File: rtl/sram_seq_ctrl_chk.sv
// Protocol checker for the SRAM sequencer, bound to the top module.
// Assumes the same clock and synchronous active-low reset.
module sram_seq_ctrl_chk #(
    parameter int ADDR_W    = 21,
    parameter int DATA_W    = 8,
    parameter int PULSE_CYC = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_sel_n,
    input logic              mem_wr_n,
    input logic              mem_rd_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_drive
);
    logic [31:0] wr_low_cnt;

    // Count the cycles the write strobe has been low.
    always_ff @(posedge clk) begin
        if (!rst_n || mem_wr_n) wr_low_cnt <= '0;
        else                    wr_low_cnt <= wr_low_cnt + 1;
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_sel_n && mem_wr_n && mem_rd_n && !mem_dq_drive));

    p_wr_in_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |-> !mem_sel_n);

    p_wr_ends_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_n) |-> !mem_sel_n);

    p_pulse_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_low_cnt <= 32'(PULSE_CYC));

    p_addr_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_sel_n && !$rose(mem_sel_n) && !$fell(mem_sel_n)) |-> $stable(mem_addr));

    p_data_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_drive && !$rose(mem_dq_drive)) |-> $stable(mem_dq_out));

    p_no_clash_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_n |-> (!mem_dq_drive && mem_wr_n));

    p_one_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PULSE_CYC (PULSE_CYC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .mem_addr     (mem_addr),
    .mem_sel_n    (mem_sel_n),
    .mem_wr_n     (mem_wr_n),
    .mem_rd_n     (mem_rd_n),
    .mem_dq_out   (mem_dq_out),
    .mem_dq_drive (mem_dq_drive)
);

// File: tb/sim_sram_seq_ctrl.sv
// Scoreboard bench for the SRAM sequencer, with a behavioural memory.
module sim_sram_seq_ctrl;
    localparam int AW = 21;
    localparam int DW = 8;
    localparam int T_SETUP = 2;
    localparam int T_PULSE = 3;
    localparam int T_HOLD  = 2;
    localparam int T_RD    = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_sel_n, mem_wr_n, mem_rd_n, mem_dq_drive;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    sram_seq_ctrl #(
        .SETUP_CYC (T_SETUP),
        .PULSE_CYC (T_PULSE),
        .HOLD_CYC  (T_HOLD),
        .RD_CYC    (T_RD)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_sel_n(mem_sel_n), .mem_wr_n(mem_wr_n), .mem_rd_n(mem_rd_n),
        .mem_dq_out(mem_dq_out), .mem_dq_drive(mem_dq_drive), .mem_dq_in(mem_dq_in)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    // Behavioural memory: it stores on the rising write strobe and shows a decoy until the last access cycle.
    logic [DW-1:0] mem [int];
    int            oe_cnt = 0;
    bit            pend = 0;
    int            pend_addr;
    logic [DW-1:0] pend_data;

    always @* begin
        if (!mem_sel_n && !mem_rd_n && mem_wr_n && oe_cnt >= T_RD)
            mem_dq_in = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
        else
            mem_dq_in = 8'hA5;
    end

    // Protocol monitor state.
    int  sel_lo = 0, wr_lo = 0, rd_lo = 0, hold_cnt = 0;
    bit  prev_sel_n = 1, prev_wr_n = 1, prev_rd_n = 1, prev_drive = 0;
    bit  in_write = 0;
    bit  clash = 0, ready_busy = 0;
    logic [DW-1:0] wr_byte;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
            finish_run();
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            oe_cnt = mem_rd_n ? 0 : oe_cnt + 1;
            sel_lo = mem_sel_n ? 0 : sel_lo + 1;
            if (!mem_rd_n && (mem_dq_drive || !mem_wr_n)) clash = 1;
            if (!mem_sel_n && req_ready) ready_busy = 1;
            // write strobe falls
            if (prev_wr_n && !mem_wr_n) begin
                in_write = 1;
                wr_byte = mem_dq_out;
                check(sel_lo == T_SETUP + 1, "R2 setup", sel_lo - 1, T_SETUP);
                check(mem_rd_n && mem_dq_drive, "R2 oe high", mem_rd_n, 1);
            end
            if (!mem_wr_n) begin
                wr_lo++;
                pend = 1; pend_addr = int'(mem_addr); pend_data = mem_dq_out;
            end
            // write strobe rises
            if (!prev_wr_n && mem_wr_n) begin
                check(wr_lo == T_PULSE, "R3 pulse", wr_lo, T_PULSE);
                check(!mem_sel_n, "R3 strobe first", mem_sel_n, 0);
                check(mem_dq_drive && mem_dq_out == wr_byte, "R4 data hold",
                      mem_dq_out, wr_byte);
                wr_lo = 0;
                hold_cnt = 0;
            end
            if (pend && mem_wr_n) begin
                mem[pend_addr] = pend_data;
                pend = 0;
            end
            if (in_write && mem_wr_n && !mem_sel_n) hold_cnt++;
            if (in_write && mem_sel_n) begin
                check(hold_cnt == T_HOLD, "R3 hold", hold_cnt, T_HOLD);
                check(!mem_dq_drive && prev_drive, "R4 drive span", mem_dq_drive, 0);
                in_write = 0;
            end
            // output enable falls / rises
            if (prev_rd_n && !mem_rd_n) begin
                check(sel_lo == 2 && !prev_drive, "R6 turnaround", sel_lo - 1, 1);
                rd_lo = 0;
            end
            if (!mem_rd_n) rd_lo++;
            if (!prev_rd_n && mem_rd_n)
                check(rd_lo == T_RD && mem_wr_n, "R6 access length", rd_lo, T_RD);
            prev_sel_n = mem_sel_n; prev_wr_n = mem_wr_n;
            prev_rd_n = mem_rd_n; prev_drive = mem_dq_drive;
        end
    end

    // Scoreboard: expected read bytes and accept cycles.
    logic [DW-1:0] ref_mem [int];
    logic [DW-1:0] exp_q [$];
    int            acc_q [$];
    int            acc_cyc;

    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(0, "R7 unexpected response", rsp_rdata, 0);
            end else begin
                logic [DW-1:0] e;
                int            a;
                e = exp_q.pop_front();
                a = acc_q.pop_front();
                check(rsp_rdata == e, "R7/R9 read data", rsp_rdata, e);
                check(cyc - a == T_RD + 1, "R7 latency", cyc - a, T_RD + 1);
            end
        end
    end

    // Driver: present a request, hold it until accepted.
    task automatic send(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        acc_cyc = cyc + 1;
        if (wr) ref_mem[int'(a)] = d;
        else begin
            exp_q.push_back(ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00);
            acc_q.push_back(acc_cyc);
        end
        #1 req_valid = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(mem_sel_n && mem_wr_n && mem_rd_n && !mem_dq_drive && req_ready,
              "R1 reset quiet", {mem_sel_n, mem_wr_n, mem_rd_n, mem_dq_drive, req_ready},
              5'b11101);
        rst_n = 1;
        // R9: same offset in all four banks
        for (int b = 0; b < 4; b++) send(1, {2'(b), 19'h01234}, 8'h11 * (b + 1));
        for (int b = 0; b < 4; b++) send(0, {2'(b), 19'h01234}, 8'h00);
        // edge addresses and data patterns
        send(1, 21'h000000, 8'hFF);
        send(1, 21'h1FFFFF, 8'h00);
        send(1, 21'h0AAAAA, 8'h5A);
        send(0, 21'h1FFFFF, 8'h00);
        send(0, 21'h000000, 8'h00);
        send(0, 21'h0AAAAA, 8'h00);
        send(0, 21'h155555, 8'h00);
        // overwrite then read straight after (write-to-read turnaround)
        send(1, 21'h0AAAAA, 8'hC3);
        send(0, 21'h0AAAAA, 8'h00);
        send(0, 21'h0AAAAA, 8'h00);
        repeat (T_RD + 6) @(negedge clk);
        check(exp_q.size() == 0, "R7 all responses", exp_q.size(), 0);
        check(!clash, "R5 no bus clash", clash, 0);
        check(!ready_busy, "R8 ready low while busy", ready_busy, 0);
        check(mem_sel_n && mem_wr_n && mem_rd_n && !mem_dq_drive && req_ready,
              "R1 idle quiet", {mem_sel_n, mem_wr_n, mem_rd_n, mem_dq_drive, req_ready},
              5'b11101);
        finish_run();
    end
endmodule